// File: doc/BRIEF.md
# Serial Audio Transmit Clock Selector

This block chooses which bit clock and which frame sync a serial audio transmitter follows and turns the chosen bit clock into single-cycle strobes in a fast system clock domain. Four sources are offered as oversampled lines: the transmitter's own pins, the local receiver's pins, a peer transmitter and a peer receiver. The bit clock source and the frame sync source are chosen separately, from a two-bit timing mode and a swap bit.

Every incoming line is synchronized first. Edges of the selected bit clock are then found by comparing the current and previous synchronized values. A polarity bit decides whether the rising edge drives outputs and the falling edge samples inputs, or the other way round. The selected frame sync is registered together with each sample strobe. A combinational flag reports transmitter and receiver settings that cannot work together. The configuration is expected to change only while the block is disabled.

Top module: `tx_clk_sel`

## Requirements
- R1: Mode 0 (asynchronous) with swap 0 takes both the bit clock and the frame sync from the transmitter lines (source 0).
- R2: Mode 0 with swap 1 takes the bit clock from the local receiver lines (source 1) and keeps the frame sync from the transmitter lines.
- R3: Mode 1 (synchronous with the local receiver) always takes the frame sync from the receiver lines. The bit clock comes from the receiver lines with swap 0 and from the transmitter lines with swap 1.
- R4: Mode 2 (peer transmitter) and mode 3 (peer receiver) take the frame sync from that peer. The bit clock comes from that peer with swap 0 and from the transmitter lines with swap 1.
- R5: With polarity 0, each rising edge of the selected bit clock gives exactly one drive strobe and each falling edge gives exactly one sample strobe. The two strobes are never high together.
- R6: With polarity 1, falling edges give drive strobes and rising edges give sample strobes.
- R7: A strobe goes high during the system cycle that follows the third rising system clock edge after the line changes, and it lasts one cycle.
- R8: The frame sync output takes the synchronized selected frame sync at the same edge that raises the sample strobe. It holds its value at all other times.
- R9: While enable is low no strobe is produced. Raising enable while the selected bit clock is already high produces no drive strobe.
- R10: The error flag is 1 when the transmitter mode and the receiver mode are both nonzero.
- R11: The error flag is 1 when the transmitter mode is nonzero and the two swap bits differ. In mode 0 the flag does not depend on the swap bits.
- R12: During and after reset, before any edge arrives, both strobes and the frame sync output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows strobes to be produced |
| cfg_mode | input | 2 | Transmitter timing mode (0 async, 1 local receiver, 2 peer transmitter, 3 peer receiver) |
| cfg_swap | input | 1 | Transmitter swap bit |
| cfg_pol | input | 1 | Bit clock polarity |
| rx_mode | input | 2 | Receiver timing mode, used only for the error check |
| rx_swap | input | 1 | Receiver swap bit, used only for the error check |
| tx_bclk_i | input | 1 | Transmitter bit clock line |
| tx_fs_i | input | 1 | Transmitter frame sync line |
| rx_bclk_i | input | 1 | Local receiver bit clock line |
| rx_fs_i | input | 1 | Local receiver frame sync line |
| ptx_bclk_i | input | 1 | Peer transmitter bit clock line |
| ptx_fs_i | input | 1 | Peer transmitter frame sync line |
| prx_bclk_i | input | 1 | Peer receiver bit clock line |
| prx_fs_i | input | 1 | Peer receiver frame sync line |
| fs_o | output | 1 | Selected frame sync, registered with each sample strobe |
| drive_stb_o | output | 1 | One-cycle drive strobe |
| sample_stb_o | output | 1 | One-cycle sample strobe |
| cfg_err_o | output | 1 | Error flag for an invalid combination of settings |

## Verification
For every mode and swap combination, the bench pulses each of the four bit clock lines in turn. Strobes must appear for exactly one line, which shows whether the bit clock choice was made independently of the frame sync choice. It then raises one frame sync line at a time and pulses the selected bit clock. This shows which frame sync source reaches the output and whether that output holds between sample strobes. Single-edge tests under both polarities pin down which edge drives, which edge samples and the exact latency. Enabling while the bit clock is already high separates a correct reload of the edge history from a false edge.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [1:0] {
    TM_ASYNC    = 2'd0,
    TM_LOCAL_RX = 2'd1,
    TM_PEER_TX  = 2'd2,
    TM_PEER_RX  = 2'd3
  } tmode_e;

  localparam int NSRC = 4;
  localparam int SRC_W = $clog2(NSRC);
  localparam logic [SRC_W-1:0] SRC_TX  = 2'd0;
  localparam logic [SRC_W-1:0] SRC_RX  = 2'd1;
  localparam logic [SRC_W-1:0] SRC_PTX = 2'd2;
  localparam logic [SRC_W-1:0] SRC_PRX = 2'd3;

  // bit clock source: asynchronous mode swaps to the receiver,
  // synchronous modes swap back to the local transmitter clock
  function automatic logic [SRC_W-1:0] bclk_pick(tmode_e m, logic swap);
    logic [SRC_W-1:0] r;
    case (m)
      TM_ASYNC:    r = swap ? SRC_RX : SRC_TX;
      TM_LOCAL_RX: r = swap ? SRC_TX : SRC_RX;
      TM_PEER_TX:  r = swap ? SRC_TX : SRC_PTX;
      default:     r = swap ? SRC_TX : SRC_PRX;
    endcase
    return r;
  endfunction

  // frame sync source depends only on the mode
  function automatic logic [SRC_W-1:0] fs_pick(tmode_e m);
    logic [SRC_W-1:0] r;
    case (m)
      TM_ASYNC:    r = SRC_TX;
      TM_LOCAL_RX: r = SRC_RX;
      TM_PEER_TX:  r = SRC_PTX;
      default:     r = SRC_PRX;
    endcase
    return r;
  endfunction

  function automatic logic cfg_bad(tmode_e tx_m, tmode_e rx_m,
                                   logic tx_sw, logic rx_sw);
    logic tx_sync;
    tx_sync = (tx_m != TM_ASYNC);
    return (tx_sync && (rx_m != TM_ASYNC)) || (tx_sync && (tx_sw != rx_sw));
  endfunction

  function automatic logic drive_edge(logic pol, logic rise, logic fall);
    return pol ? fall : rise;
  endfunction

  function automatic logic sample_edge(logic pol, logic rise, logic fall);
    return pol ? rise : fall;
  endfunction

endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
  import tcs_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [1:0]   mode,
  input  logic         swap,
  input  logic [N-1:0] bclk_vec,
  input  logic [N-1:0] fs_vec,
  output logic         bclk_sel,
  output logic         fs_sel
);

  logic [SRC_W-1:0] b_idx;
  logic [SRC_W-1:0] f_idx;

  always_comb begin
    b_idx    = bclk_pick(tmode_e'(mode), swap);
    f_idx    = fs_pick(tmode_e'(mode));
    bclk_sel = bclk_vec[b_idx];
    fs_sel   = fs_vec[f_idx];
  end

endmodule

// File: rtl/tcs_edge.sv
module tcs_edge
  import tcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pol,
  input  logic bclk,
  input  logic fs,
  output logic rise,
  output logic fall,
  output logic drive_stb,
  output logic sample_stb,
  output logic fs_q
);

  logic prev;
  logic drv_ev;
  logic smp_ev;

  assign rise   = bclk & ~prev;
  assign fall   = ~bclk & prev;
  assign drv_ev = en & drive_edge(pol, rise, fall);
  assign smp_ev = en & sample_edge(pol, rise, fall);

  // history always tracks the line, so a disabled block reloads it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev       <= 1'b0;
      drive_stb  <= 1'b0;
      sample_stb <= 1'b0;
      fs_q       <= 1'b0;
    end else begin
      prev       <= bclk;
      drive_stb  <= drv_ev;
      sample_stb <= smp_ev;
      if (smp_ev) fs_q <= fs;
    end
  end

endmodule

// File: rtl/tx_clk_sel.sv
module tx_clk_sel
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_swap,
  input  logic       cfg_pol,
  input  logic [1:0] rx_mode,
  input  logic       rx_swap,
  input  logic       tx_bclk_i,
  input  logic       tx_fs_i,
  input  logic       rx_bclk_i,
  input  logic       rx_fs_i,
  input  logic       ptx_bclk_i,
  input  logic       ptx_fs_i,
  input  logic       prx_bclk_i,
  input  logic       prx_fs_i,
  output logic       fs_o,
  output logic       drive_stb_o,
  output logic       sample_stb_o,
  output logic       cfg_err_o
);

  localparam int LINES = 2 * NSRC;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] sync_lines;
  logic [NSRC-1:0]  bclk_vec;
  logic [NSRC-1:0]  fs_vec;
  logic             bclk_sel_w;
  logic             fs_sel_w;
  logic             rise_w;
  logic             fall_w;

  assign raw_lines = {prx_fs_i, ptx_fs_i, rx_fs_i, tx_fs_i,
                      prx_bclk_i, ptx_bclk_i, rx_bclk_i, tx_bclk_i};

  tcs_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_lines),
    .q     (sync_lines)
  );

  assign bclk_vec = sync_lines[NSRC-1:0];
  assign fs_vec   = sync_lines[LINES-1:NSRC];

  tcs_src_mux #(.N(NSRC)) u_mux (
    .mode     (cfg_mode),
    .swap     (cfg_swap),
    .bclk_vec (bclk_vec),
    .fs_vec   (fs_vec),
    .bclk_sel (bclk_sel_w),
    .fs_sel   (fs_sel_w)
  );

  tcs_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (enable),
    .pol        (cfg_pol),
    .bclk       (bclk_sel_w),
    .fs         (fs_sel_w),
    .rise       (rise_w),
    .fall       (fall_w),
    .drive_stb  (drive_stb_o),
    .sample_stb (sample_stb_o),
    .fs_q       (fs_o)
  );

  assign cfg_err_o = cfg_bad(tmode_e'(cfg_mode), tmode_e'(rx_mode), cfg_swap, rx_swap);

endmodule

// File: rtl/tcs_chk.sv
module tcs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [1:0] cfg_mode,
  input logic       cfg_swap,
  input logic       cfg_pol,
  input logic [1:0] rx_mode,
  input logic       rx_swap,
  input logic       rise_w,
  input logic       fall_w,
  input logic       fs_o,
  input logic       drive_stb_o,
  input logic       sample_stb_o,
  input logic       cfg_err_o
);

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_stb_o && sample_stb_o));

  a_r5_rise_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && enable && !cfg_pol) |=> drive_stb_o);

  a_r6_rise_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && enable && cfg_pol) |=> sample_stb_o);

  a_r6_fall_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_w && enable && cfg_pol) |=> drive_stb_o);

  a_r8_fs_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb_o |-> $stable(fs_o));

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!drive_stb_o && !sample_stb_o));

  a_r10_both_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'd0 && rx_mode != 2'd0) |-> cfg_err_o);

  a_r11_swap_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'd0 && cfg_swap != rx_swap) |-> cfg_err_o);

  a_r11_async_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0) |-> !cfg_err_o);

endmodule

bind tx_clk_sel tcs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .cfg_mode     (cfg_mode),
  .cfg_swap     (cfg_swap),
  .cfg_pol      (cfg_pol),
  .rx_mode      (rx_mode),
  .rx_swap      (rx_swap),
  .rise_w       (rise_w),
  .fall_w       (fall_w),
  .fs_o         (fs_o),
  .drive_stb_o  (drive_stb_o),
  .sample_stb_o (sample_stb_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/tx_clk_sel_bench.sv
`timescale 1ns/1ps
module tx_clk_sel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_swap = 1'b0;
  logic       cfg_pol = 1'b0;
  logic [1:0] rx_mode = 2'd0;
  logic       rx_swap = 1'b0;
  logic [3:0] bl = 4'd0;   // 0 tx, 1 rx, 2 peer tx, 3 peer rx
  logic [3:0] fl = 4'd0;
  logic       fs_o, drive_stb_o, sample_stb_o, cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_drv = 0;
  int n_smp = 0;
  logic counting = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  tx_clk_sel u_tx_clk_sel (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_mode(cfg_mode), .cfg_swap(cfg_swap), .cfg_pol(cfg_pol),
    .rx_mode(rx_mode), .rx_swap(rx_swap),
    .tx_bclk_i(bl[0]), .tx_fs_i(fl[0]),
    .rx_bclk_i(bl[1]), .rx_fs_i(fl[1]),
    .ptx_bclk_i(bl[2]), .ptx_fs_i(fl[2]),
    .prx_bclk_i(bl[3]), .prx_fs_i(fl[3]),
    .fs_o(fs_o), .drive_stb_o(drive_stb_o),
    .sample_stb_o(sample_stb_o), .cfg_err_o(cfg_err_o)
  );

  always @(negedge clk) if (counting) begin
    n_drv += int'(drive_stb_o);
    n_smp += int'(sample_stb_o);
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(logic [1:0] m, logic sw, logic p);
    @(negedge clk);
    enable = 1'b0;
    cfg_mode = m; cfg_swap = sw; cfg_pol = p;
    rx_mode = 2'd0; rx_swap = sw;
    repeat (6) @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_count(int line);
    n_drv = 0; n_smp = 0;
    counting = 1'b1;
    bl[line] = 1'b1;
    repeat (6) @(negedge clk);
    bl[line] = 1'b0;
    repeat (6) @(negedge clk);
    counting = 1'b0;
  endtask

  // routing of bit clock and frame sync for one mode/swap
  task automatic t_route(string req, logic [1:0] m, logic sw, int eb, int ef);
    configure(m, sw, 1'b0);
    for (int i = 0; i < 4; i++) begin
      pulse_count(i);
      check({req, " bclk drive"}, n_drv, (i == eb) ? 1 : 0);
      check({req, " bclk sample"}, n_smp, (i == eb) ? 1 : 0);
    end
    for (int i = 0; i < 4; i++) begin
      fl = 4'd0;
      fl[i] = 1'b1;
      pulse_count(eb);
      check({req, " fs source"}, int'(fs_o), (i == ef) ? 1 : 0);
    end
    fl = 4'd0;
    pulse_count(eb);
  endtask

  // exact latency and edge meaning for one polarity
  task automatic t_edge(string req, logic p);
    configure(2'd0, 1'b0, p);
    bl[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({req, " R7 rise latency drive"}, int'(drive_stb_o), p ? 0 : 1);
    check({req, " R7 rise latency sample"}, int'(sample_stb_o), p ? 1 : 0);
    @(negedge clk);
    check({req, " R7 one cycle"}, int'(drive_stb_o | sample_stb_o), 0);
    repeat (3) @(negedge clk);
    bl[0] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({req, " fall drive"}, int'(drive_stb_o), p ? 1 : 0);
    check({req, " fall sample"}, int'(sample_stb_o), p ? 0 : 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_fs_hold();
    configure(2'd0, 1'b0, 1'b0);
    fl[0] = 1'b1;
    pulse_count(0);
    check("R8 fs captured", int'(fs_o), 1);
    fl[0] = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 fs holds without sample edge", int'(fs_o), 1);
    bl[0] = 1'b1;
    repeat (8) @(negedge clk);
    check("R8 fs holds over drive edge", int'(fs_o), 1);
    bl[0] = 1'b0;
    repeat (8) @(negedge clk);
    check("R8 fs follows sample edge", int'(fs_o), 0);
  endtask

  task automatic t_disable();
    configure(2'd0, 1'b0, 1'b0);
    @(negedge clk);
    enable = 1'b0;
    pulse_count(0);
    check("R9 disabled drive", n_drv, 0);
    check("R9 disabled sample", n_smp, 0);
    bl[0] = 1'b1;
    repeat (6) @(negedge clk);
    n_drv = 0; n_smp = 0;
    counting = 1'b1;
    enable = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 enable while high no drive", n_drv, 0);
    bl[0] = 1'b0;
    repeat (6) @(negedge clk);
    counting = 1'b0;
    check("R9 later fall still samples", n_smp, 1);
  endtask

  task automatic t_cfg_err();
    @(negedge clk);
    enable = 1'b0;
    cfg_mode = 2'd2; rx_mode = 2'd1; cfg_swap = 1'b0; rx_swap = 1'b0;
    #1 check("R10 both synchronous", int'(cfg_err_o), 1);
    rx_mode = 2'd0;
    #1 check("R10 only tx synchronous", int'(cfg_err_o), 0);
    cfg_mode = 2'd1; cfg_swap = 1'b1;
    #1 check("R11 swap mismatch", int'(cfg_err_o), 1);
    rx_swap = 1'b1;
    #1 check("R11 swap match", int'(cfg_err_o), 0);
    cfg_mode = 2'd0; rx_swap = 1'b0;
    #1 check("R11 async ignores swaps", int'(cfg_err_o), 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R12 reset drive", int'(drive_stb_o), 0);
    check("R12 reset sample", int'(sample_stb_o), 0);
    check("R12 reset fs", int'(fs_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 idle after reset", int'(drive_stb_o | sample_stb_o | fs_o), 0);

    t_route("R1 async",       2'd0, 1'b0, 0, 0);
    t_route("R2 async swap",  2'd0, 1'b1, 1, 0);
    t_route("R3 local rx",    2'd1, 1'b0, 1, 1);
    t_route("R3 local rx sw", 2'd1, 1'b1, 0, 1);
    t_route("R4 peer tx",     2'd2, 1'b0, 2, 2);
    t_route("R4 peer rx sw",  2'd3, 1'b1, 0, 3);
    t_edge("R5 pol0", 1'b0);
    t_edge("R6 pol1", 1'b1);
    t_fs_hold();
    t_disable();
    t_cfg_err();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule